// File: doc/BRIEF.md
# Dual-Sample Synchronizer Failure Counter

This block measures how often a synchronizer has not settled at two resolution times. Two external capture flops latch the synchronizer output on two strobes, an early one and a late one, placed after the synchronizer clock. Their results reach this block as `tap_early` and `tap_late`. The synchronizer output itself arrives on `tap_final`. The block registers both taps on a local clock edge. On the next edge it compares each registered tap with `tap_final`, and any difference is counted as a failure at that sampling point.

Each sampling point has its own saturating failure counter. A third saturating counter counts the enabled observation cycles, and a parameter can remove it. The decay time constant of the synchronizer comes from the ratio of the two failure counts and the known strobe spacing. The MTBF comes from either count and the cycle count. That arithmetic is done downstream. A snapshot request copies all three live counts into output registers on a single edge, so the reader always sees one consistent set.

Top module: `dual_sample_fail_counter`

## Requirements
- R1: While `rst_n` is low at a rising edge, all live counters, the sample stage and all three snapshot outputs become zero.
- R2: If `meas_en` is high and `cnt_clr` is low at edge k, and `cnt_clr` is low at edge k+1, then the early failure count rises by one at edge k+1 when the `tap_early` value captured at edge k differs from `tap_final` at edge k+1. Otherwise it does not change.
- R3: The late failure count follows the same rule as R2, using `tap_late`, and it is independent of the early count.
- R4: The cycle count rises by one at every edge at which a sample captured on the previous edge is compared, whether or not that sample shows a mismatch.
- R5: A sample captured while `meas_en` is low changes none of the three counts, whatever the tap values are.
- R6: `cnt_clr` high at an edge sets all three live counts to zero and discards the sample captured at that edge.
- R7: Every counter holds at its all-ones value instead of wrapping. This is 2^FAIL_W-1 for the failure counts and 2^CYC_W-1 for the cycle count.
- R8: `snap_req` high at an edge loads all three snapshot outputs with the live counts held just before that edge. While `snap_req` is low, the snapshot outputs do not change.
- R9: With HAS_CYCLE = 0, `snap_cycles` stays zero and both failure counts behave as in R2 and R3.
- R10: If `snap_req` and `cnt_clr` are high at the same edge, the snapshot receives the counts held before the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Synchronous active-low reset |
| meas_en | input | 1 | Marks the sample captured at this edge as part of the measurement window |
| cnt_clr | input | 1 | Clears the live counts |
| snap_req | input | 1 | Copies the live counts to the snapshot outputs |
| tap_early | input | 1 | Synchronizer output latched by the early strobe |
| tap_late | input | 1 | Synchronizer output latched by the late strobe |
| tap_final | input | 1 | Synchronizer output as registered by the local clock |
| snap_fail_early | output | FAIL_W | Snapshot of the early failure count |
| snap_fail_late | output | FAIL_W | Snapshot of the late failure count |
| snap_cycles | output | CYC_W | Snapshot of the cycle count, zero when HAS_CYCLE = 0 |

## Verification
The live counts reach the ports only through a snapshot. A wrong count, a lost sample or a missed clear therefore shows at the outputs on the first snapshot edge after the fault, and the error stays visible until the next snapshot. A wrong stage alignment adds or drops one failure per mismatching cycle. Snapshots are taken every few cycles, including one on the same edge as a clear, so any divergence shows within a handful of cycles. Small counter widths drive all three counters into saturation within one short window, so a wrap shows as a drop to a small value.

// File: rtl/dsfc_pkg.sv
// Shared types for the dual-sample failure counter.
// Assumes: two sampling points, early then late.
package dsfc_pkg;

    // Index of a sampling point in the failure vectors.
    typedef enum logic {
        PT_EARLY = 1'b0,
        PT_LATE  = 1'b1
    } sample_pt_e;

    localparam int NUM_PTS = 2;

    // Pair of captured tap values, one per sampling point.
    typedef struct packed {
        logic late;
        logic early;
    } tap_pair_t;

endpackage

// File: rtl/dsfc_sampler.sv
// Captures the two strobe-latched taps on the local clock.
// On the next edge it compares each captured tap with the settled value.
// Assumes: the taps are stable at the local clock edge. The external
// strobes guarantee this by latching them well before the edge.
module dsfc_sampler
    import dsfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               meas_en,
    input  logic               cnt_clr,
    input  logic               tap_early,
    input  logic               tap_late,
    input  logic               tap_final,
    output logic               stage_vld,
    output logic [NUM_PTS-1:0] miss
);

    tap_pair_t held;

    // Hold the taps and mark whether they belong to the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= '0;
            stage_vld <= 1'b0;
        end else begin
            held.early <= tap_early;
            held.late  <= tap_late;
            stage_vld  <= meas_en & ~cnt_clr;
        end
    end

    // Flag a failure at each point whose sample differs from the settled value.
    always_comb begin
        miss           = '0;
        miss[PT_EARLY] = stage_vld & (held.early ^ tap_final);
        miss[PT_LATE]  = stage_vld & (held.late  ^ tap_final);
    end

endmodule

// File: rtl/dsfc_sat_counter.sv
// Saturating up-counter with a synchronous clear.
// Assumes: clear takes priority over increment.
module dsfc_sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count events, stopping at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != TOP)) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dsfc_snapshot.sv
// Output register loaded from a live count on request.
// Assumes: the request is one local-clock cycle wide or level, either works.
module dsfc_snapshot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Copy the live value when asked, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/dual_sample_fail_counter.sv
// Counts synchronizer failures at two resolution times and the enabled
// cycles, and presents a consistent snapshot of the three counts.
// Assumes: the strobe spacing is set outside the block, and any spacing
// is accepted. HAS_CYCLE = 0 removes the cycle counter.
module dual_sample_fail_counter
    import dsfc_pkg::*;
#(
    parameter int FAIL_W    = 16,
    parameter int CYC_W     = 24,
    parameter bit HAS_CYCLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meas_en,
    input  logic              cnt_clr,
    input  logic              snap_req,
    input  logic              tap_early,
    input  logic              tap_late,
    input  logic              tap_final,
    output logic [FAIL_W-1:0] snap_fail_early,
    output logic [FAIL_W-1:0] snap_fail_late,
    output logic [CYC_W-1:0]  snap_cycles
);

    logic                stage_vld;
    logic [NUM_PTS-1:0]  miss;
    logic [FAIL_W-1:0]   fail_cnt  [NUM_PTS];
    logic [FAIL_W-1:0]   fail_snap [NUM_PTS];
    logic [CYC_W-1:0]    cyc_cnt;

    dsfc_sampler u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .meas_en   (meas_en),
        .cnt_clr   (cnt_clr),
        .tap_early (tap_early),
        .tap_late  (tap_late),
        .tap_final (tap_final),
        .stage_vld (stage_vld),
        .miss      (miss)
    );

    // One failure counter and one snapshot register per sampling point.
    for (genvar p = 0; p < NUM_PTS; p++) begin : g_pt
        dsfc_sat_counter #(.W(FAIL_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (miss[p]),
            .cnt   (fail_cnt[p])
        );
        dsfc_snapshot #(.W(FAIL_W)) u_snap (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (snap_req),
            .d     (fail_cnt[p]),
            .q     (fail_snap[p])
        );
    end

    // Optional observation-window counter.
    if (HAS_CYCLE) begin : g_cyc
        dsfc_sat_counter #(.W(CYC_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (stage_vld),
            .cnt   (cyc_cnt)
        );
        dsfc_snapshot #(.W(CYC_W)) u_snap (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (snap_req),
            .d     (cyc_cnt),
            .q     (snap_cycles)
        );
    end else begin : g_nocyc
        assign cyc_cnt     = '0;
        assign snap_cycles = '0;
    end

    assign snap_fail_early = fail_snap[PT_EARLY];
    assign snap_fail_late  = fail_snap[PT_LATE];

endmodule

// File: rtl/dsfc_checker.sv
// Temporal checks on the failure counter, bound to the top module.
// Assumes: live counts are observed through the top's internal arrays.
module dsfc_checker #(
    parameter int FAIL_W    = 16,
    parameter int CYC_W     = 24,
    parameter bit HAS_CYCLE = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic              snap_req,
    input logic              stage_vld,
    input logic [FAIL_W-1:0] live_early,
    input logic [FAIL_W-1:0] live_late,
    input logic [CYC_W-1:0]  live_cyc,
    input logic [FAIL_W-1:0] snap_fail_early,
    input logic [FAIL_W-1:0] snap_fail_late,
    input logic [CYC_W-1:0]  snap_cycles
);

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (live_early == $past(live_early)) ||
                     (live_early == $past(live_early) + 1'b1));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> (live_late == $past(live_late)) ||
                     (live_late == $past(live_late) + 1'b1));

    p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stage_vld && !cnt_clr) |=> $stable(live_early) && $stable(live_late)
                                     && $stable(live_cyc));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (live_early == '0) && (live_late == '0) && (live_cyc == '0));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_early == '1) && !cnt_clr) |=> (live_early == '1));

    p_no_wrap_late_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((live_late == '1) && !cnt_clr) |=> (live_late == '1));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(snap_fail_early) && $stable(snap_fail_late)
                      && $stable(snap_cycles));

    p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (snap_fail_early == $past(live_early)) &&
                     (snap_fail_late == $past(live_late)));

    if (HAS_CYCLE) begin : g_cyc_chk
        p_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (stage_vld && !cnt_clr && (live_cyc != '1))
                |=> (live_cyc == $past(live_cyc) + 1'b1));
    end else begin : g_nocyc_chk
        p_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            snap_req |=> (snap_cycles == '0));
    end

endmodule

bind dual_sample_fail_counter dsfc_checker #(
    .FAIL_W    (FAIL_W),
    .CYC_W     (CYC_W),
    .HAS_CYCLE (HAS_CYCLE)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cnt_clr         (cnt_clr),
    .snap_req        (snap_req),
    .stage_vld       (stage_vld),
    .live_early      (fail_cnt[0]),
    .live_late       (fail_cnt[1]),
    .live_cyc        (cyc_cnt),
    .snap_fail_early (snap_fail_early),
    .snap_fail_late  (snap_fail_late),
    .snap_cycles     (snap_cycles)
);

// File: tb/sim_dual_sample_fail_counter.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on every edge and compared
// with both instances on every falling edge.
module sim_dual_sample_fail_counter;

    localparam int FW   = 4;
    localparam int CW   = 6;
    localparam int FMAX = 15;
    localparam int CMAX = 63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic meas_en = 1'b0, cnt_clr = 1'b0, snap_req = 1'b0;
    logic tap_early = 1'b0, tap_late = 1'b0, tap_final = 1'b0;
    logic [FW-1:0] se0, sl0, se1, sl1;
    logic [CW-1:0] sc0, sc1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Reference model state.
    int m_fe = 0, m_fl = 0, m_cy = 0;
    int o_fe = 0, o_fl = 0, o_cy = 0;
    int m_se = 0, m_sl = 0, m_v = 0;

    always #2 clk = ~clk;

    dual_sample_fail_counter #(.FAIL_W(FW), .CYC_W(CW), .HAS_CYCLE(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .cnt_clr(cnt_clr),
        .snap_req(snap_req), .tap_early(tap_early), .tap_late(tap_late),
        .tap_final(tap_final), .snap_fail_early(se0), .snap_fail_late(sl0),
        .snap_cycles(sc0));

    dual_sample_fail_counter #(.FAIL_W(FW), .CYC_W(CW), .HAS_CYCLE(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .meas_en(meas_en), .cnt_clr(cnt_clr),
        .snap_req(snap_req), .tap_early(tap_early), .tap_late(tap_late),
        .tap_final(tap_final), .snap_fail_early(se1), .snap_fail_late(sl1),
        .snap_cycles(sc1));

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model: snapshot first, then clear or count, then capture.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_fe = 0; m_fl = 0; m_cy = 0; o_fe = 0; o_fl = 0; o_cy = 0;
            m_se = 0; m_sl = 0; m_v = 0;
        end else begin
            if (snap_req) begin o_fe = m_fe; o_fl = m_fl; o_cy = m_cy; end
            if (cnt_clr) begin
                m_fe = 0; m_fl = 0; m_cy = 0; m_v = 0;
            end else begin
                if (m_v != 0) begin
                    if (m_se != int'(tap_final) && m_fe < FMAX) m_fe++;
                    if (m_sl != int'(tap_final) && m_fl < FMAX) m_fl++;
                    if (m_cy < CMAX) m_cy++;
                end
                m_v = int'(meas_en);
            end
            m_se = int'(tap_early);
            m_sl = int'(tap_late);
        end
    end

    // Compare both instances with the model away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk({cur_req, " early"}, int'(se0), o_fe);
            chk({cur_req, " late"},  int'(sl0), o_fl);
            chk({cur_req, " cycles"}, int'(sc0), o_cy);
            chk("R9 early", int'(se1), o_fe);
            chk("R9 late",  int'(sl1), o_fl);
            chk("R9 cycles", int'(sc1), 0);
        end
    end

    task automatic drive(input logic en, input logic clr, input logic snp,
                         input logic te, input logic tl, input logic tf);
        @(negedge clk);
        #0.5;
        meas_en = en; cnt_clr = clr; snap_req = snp;
        tap_early = te; tap_late = tl; tap_final = tf;
    endtask

    // Watchdog: a hung run ends as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=timeout expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic tf_prev = 1'b0;
        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset early", int'(se0), 0);
        chk("R1 reset cycles", int'(sc0), 0);
        #0.5 rst_n = 1'b1;

        // R4: agreeing taps, only the cycle count grows.
        cur_req = "R4";
        for (int i = 0; i < 8; i++) drive(1, 0, (i == 7), 1, 1, 1);
        drive(0, 0, 0, 1, 1, 1);
        @(negedge clk);
        chk("R4 cycles after 8 enabled", int'(sc0), 6);

        // R2: early tap disagrees with the next settled value.
        cur_req = "R2";
        for (int i = 0; i < 10; i++) begin
            drive(1, 0, (i % 3 == 2), ~tf_prev ? 1'b0 : 1'b1, ~tf_prev, ~tf_prev);
            tf_prev = ~tf_prev;
        end
        // R3: only the late tap disagrees.
        cur_req = "R3";
        for (int i = 0; i < 10; i++) drive(1, 0, (i % 4 == 3), 1, 0, 1);
        drive(1, 0, 1, 1, 1, 1);

        // R6: clear, then snapshot shows zero.
        cur_req = "R6";
        drive(0, 1, 0, 0, 0, 1);
        drive(0, 0, 1, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R6 early after clear", int'(se0), 0);
        chk("R6 cycles after clear", int'(sc0), 0);

        // R5: disabled window with mismatching taps.
        cur_req = "R5";
        for (int i = 0; i < 10; i++) drive(0, 0, 0, i[0], ~i[0], 1);
        drive(0, 0, 1, 1, 1, 1);
        drive(0, 0, 0, 1, 1, 1);
        chk("R5 early while disabled", int'(se0), 0);
        chk("R5 late while disabled", int'(sl0), 0);

        // R7: long mismatch run saturates every counter.
        cur_req = "R7";
        for (int i = 0; i < 80; i++) drive(1, 0, 0, 0, 0, 1);
        drive(1, 0, 1, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R7 early saturated", int'(se0), FMAX);
        chk("R7 late saturated", int'(sl0), FMAX);
        chk("R7 cycles saturated", int'(sc0), CMAX);

        // R10: snapshot and clear on the same edge.
        cur_req = "R10";
        drive(1, 1, 1, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R10 snapshot keeps pre-clear value", int'(se0), FMAX);
        drive(0, 0, 1, 0, 0, 1);
        drive(0, 0, 0, 0, 0, 1);
        chk("R10 later snapshot after clear", int'(se0), 0);

        // R8: mixed traffic with periodic snapshots and rare clears.
        cur_req = "R8";
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(lfsr[0] | lfsr[5], (lfsr[15:11] == 5'd3), (i % 5 == 4),
                  lfsr[1], lfsr[2] & lfsr[3], lfsr[4]);
        end
        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule